// File: doc/BRIEF.md
# Interlocked Three-Pair Non-Overlapping Phase Generator

This block derives six switching phases for an alternating-phase switched-capacitor pipeline from one fast master clock. Two main phases, `main_a` and `main_b`, take turns and are separated by a programmable dead time. Each main phase also carries a nested pair of shorter sub-phases inside its high window. The shift pair `shift_a`/`shift_b` sits inside `main_b`, and the mirror pair `mirr_a`/`mirr_b` sits inside `main_a`. The nested pairs serve the stages that hold on the other half of the cycle.

All edges are set by one period counter and a set of window comparators, so no delay cells are needed. Three lengths, all counted in master-clock cycles, are programmable: the dead time `D`, the sub-phase length `S` and the main-phase length `H`. Any illegal setting is raised to the nearest legal one. New settings take effect only at a period boundary. Every output leaves a flip-flop.

Top module: `nolap_clkgen`

## Requirements
- R1: While `rst` is sampled high at a rising edge, all six outputs are low after that edge.
- R2: `main_a` and `main_b` are never high in the same cycle. Between the fall of either one and the rise of the other, both stay low for exactly `D` cycles.
- R3: One period lasts `2*(H+D)` cycles. `main_a` is high for the first `H` cycles of the period. `main_b` is high for `H` cycles starting at cycle `H+D`. After reset the first output cycle is period cycle 0.
- R4: `shift_a` rises in the same cycle as `main_b` and stays high for `S` cycles. After a gap of `D` cycles, `shift_b` is high for `S` cycles. Neither is ever high while `main_b` is low.
- R5: `mirr_a` and `mirr_b` have the same timing relative to `main_a` that `shift_a`/`shift_b` have relative to `main_b`. Neither is ever high while `main_a` is low.
- R6: `shift_a` and `shift_b` are never both high, and `mirr_a` and `mirr_b` are never both high.
- R7: A dead time of 0 is used as 1 and a sub-phase length of 0 is used as 1. A main length below `2*S+D` is raised to `2*S+D`.
- R8: The settings are captured in the reset cycle and in the last cycle of each period. A change at any other time has no effect until the next period begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous reset, active high |
| dead_cyc | input | W | dead time D in cycles |
| sub_cyc | input | W | sub-phase length S in cycles |
| half_cyc | input | W | main-phase length H in cycles |
| main_a | output | 1 | first main phase |
| main_b | output | 1 | second main phase |
| shift_a | output | 1 | first sub-phase inside `main_b` |
| shift_b | output | 1 | second sub-phase inside `main_b` |
| mirr_a | output | 1 | first sub-phase inside `main_a` |
| mirr_b | output | 1 | second sub-phase inside `main_a` |

## Verification
The hardest case to reach from the ports is a settings change that lands in the middle of a period. Only the boundary capture keeps the windows of that period aligned with each other. The stimulus reaches this case in two ways. In one segment it redraws all three settings on every cycle. It also mixes random legal settings with directed zero, undersized and near-maximum values. The bench's own period model then predicts every output cycle by cycle.

// File: rtl/nolap_clkgen_pkg.sv
package nolap_clkgen_pkg;
   localparam int NWIN = 6;
   // window slots; order fixes the output bit order
   localparam int WIN_MAIN_A  = 0;
   localparam int WIN_MAIN_B  = 1;
   localparam int WIN_SHIFT_A = 2;
   localparam int WIN_SHIFT_B = 3;
   localparam int WIN_MIRR_A  = 4;
   localparam int WIN_MIRR_B  = 5;
endpackage

// File: rtl/cg_cfg_hold.sv
module cg_cfg_hold #(
   parameter int W  = 8,
   parameter int CW = W + 3
) (
   input  logic          clk,
   input  logic          load,
   input  logic [W-1:0]  dead_in,
   input  logic [W-1:0]  sub_in,
   input  logic [W-1:0]  half_in,
   output logic [CW-1:0] dead_q,
   output logic [CW-1:0] sub_q,
   output logic [CW-1:0] half_q
);
   logic [CW-1:0] d_fix, s_fix, h_raw, h_min, h_fix;

   always_comb begin
      d_fix = (dead_in == '0) ? CW'(1) : CW'(dead_in);
      s_fix = (sub_in  == '0) ? CW'(1) : CW'(sub_in);
      h_raw = CW'(half_in);
      h_min = (s_fix << 1) + d_fix;
      h_fix = (h_raw < h_min) ? h_min : h_raw;
   end

   always_ff @(posedge clk) begin
      if (load) begin
         dead_q <= d_fix;
         sub_q  <= s_fix;
         half_q <= h_fix;
      end
   end
endmodule

// File: rtl/cg_period_cnt.sv
module cg_period_cnt #(
   parameter int CW = 11
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] last,
   output logic [CW-1:0] cnt,
   output logic          wrap
);
   assign wrap = (cnt == last);

   always_ff @(posedge clk) begin
      if (rst || wrap) cnt <= '0;
      else             cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/cg_window.sv
module cg_window #(
   parameter int CW = 11
) (
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] start,
   input  logic [CW-1:0] len,
   output logic          on
);
   logic [CW-1:0] stop;
   assign stop = start + len;
   assign on   = (cnt >= start) && (cnt < stop);
endmodule

// File: rtl/nolap_clkgen.sv
module nolap_clkgen #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] dead_cyc,
   input  logic [W-1:0] sub_cyc,
   input  logic [W-1:0] half_cyc,
   output logic         main_a,
   output logic         main_b,
   output logic         shift_a,
   output logic         shift_b,
   output logic         mirr_a,
   output logic         mirr_b
);
   import nolap_clkgen_pkg::*;

   localparam int CW = W + 3;

   if (W < 2 || W > 16) begin : g_bad_w
      $error("nolap_clkgen: W out of range");
   end

   logic [CW-1:0] d_c, s_c, h_c, cnt, last, b_start;
   logic          wrap;
   logic [CW-1:0] win_start [NWIN];
   logic [CW-1:0] win_len   [NWIN];
   logic [NWIN-1:0] win_on, phase_q;

   cg_cfg_hold #(.W(W), .CW(CW)) u_cfg (
      .clk(clk), .load(rst | wrap),
      .dead_in(dead_cyc), .sub_in(sub_cyc), .half_in(half_cyc),
      .dead_q(d_c), .sub_q(s_c), .half_q(h_c)
   );

   assign last = ((h_c + d_c) << 1) - CW'(1);

   cg_period_cnt #(.CW(CW)) u_cnt (
      .clk(clk), .rst(rst), .last(last), .cnt(cnt), .wrap(wrap)
   );

   always_comb begin
      b_start = h_c + d_c;
      win_start[WIN_MAIN_A]  = '0;
      win_len  [WIN_MAIN_A]  = h_c;
      win_start[WIN_MAIN_B]  = b_start;
      win_len  [WIN_MAIN_B]  = h_c;
      win_start[WIN_SHIFT_A] = b_start;
      win_len  [WIN_SHIFT_A] = s_c;
      win_start[WIN_SHIFT_B] = b_start + s_c + d_c;
      win_len  [WIN_SHIFT_B] = s_c;
      win_start[WIN_MIRR_A]  = '0;
      win_len  [WIN_MIRR_A]  = s_c;
      win_start[WIN_MIRR_B]  = s_c + d_c;
      win_len  [WIN_MIRR_B]  = s_c;
   end

   for (genvar i = 0; i < NWIN; i++) begin : g_win
      cg_window #(.CW(CW)) u_win (
         .cnt(cnt), .start(win_start[i]), .len(win_len[i]), .on(win_on[i])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) phase_q <= '0;
      else     phase_q <= win_on;
   end

   assign main_a  = phase_q[WIN_MAIN_A];
   assign main_b  = phase_q[WIN_MAIN_B];
   assign shift_a = phase_q[WIN_SHIFT_A];
   assign shift_b = phase_q[WIN_SHIFT_B];
   assign mirr_a  = phase_q[WIN_MIRR_A];
   assign mirr_b  = phase_q[WIN_MIRR_B];
endmodule

// File: rtl/nolap_clkgen_chk.sv
module nolap_clkgen_chk (
   input logic clk,
   input logic rst,
   input logic main_a,
   input logic main_b,
   input logic shift_a,
   input logic shift_b,
   input logic mirr_a,
   input logic mirr_b
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> !(main_a | main_b | shift_a | shift_b | mirr_a | mirr_b));

   // R2
   main_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(main_a && main_b));

   // R2
   main_gap_chk: assert property (@(posedge clk) disable iff (rst)
      ($fell(main_a) || $fell(main_b)) |-> !(main_a || main_b));

   // R4
   shift_nest_chk: assert property (@(posedge clk) disable iff (rst)
      (shift_a || shift_b) |-> main_b);

   // R4
   shift_start_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(main_b) |-> shift_a);

   // R5
   mirr_nest_chk: assert property (@(posedge clk) disable iff (rst)
      (mirr_a || mirr_b) |-> main_a);

   // R6
   sub_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(shift_a && shift_b) && !(mirr_a && mirr_b));
endmodule

bind nolap_clkgen nolap_clkgen_chk u_chk (
   .clk(clk), .rst(rst),
   .main_a(main_a), .main_b(main_b),
   .shift_a(shift_a), .shift_b(shift_b),
   .mirr_a(mirr_a), .mirr_b(mirr_b)
);

// File: tb/sim_nolap_clkgen.sv
module sim_nolap_clkgen;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] dead_cyc = '0, sub_cyc = '0, half_cyc = '0;
   logic main_a, main_b, shift_a, shift_b, mirr_a, mirr_b;

   int checks = 0, errors = 0, cycles = 0;
   int md, ms, mh, mt;
   logic [5:0] expv;
   logic [5:0] prev;

   always #5 clk = ~clk;

   nolap_clkgen #(.W(W)) u0 (.*);

   function automatic int fix_d(int v); return (v == 0) ? 1 : v; endfunction
   function automatic int fix_s(int v); return (v == 0) ? 1 : v; endfunction
   function automatic int fix_h(int h, int s, int d);
      return (h < 2*s + d) ? 2*s + d : h;
   endfunction
   function automatic bit inwin(int t, int st, int ln);
      return (t >= st) && (t < st + ln);
   endfunction

   task automatic latch_cfg();
      md = fix_d(int'(dead_cyc));
      ms = fix_s(int'(sub_cyc));
      mh = fix_h(int'(half_cyc), ms, md);
   endtask

   task automatic chk(string req, logic [1:0] act, logic [1:0] ex);
      checks++;
      if (act !== ex) begin
         errors++;
         $display("FAIL %s cycle %0d actual %b expected %b", req, cycles, act, ex);
      end
   endtask

   task automatic tick(string tag);
      @(posedge clk);
      if (rst) begin
         expv = '0; mt = 0; latch_cfg();
      end else begin
         expv[5] = inwin(mt, 0, mh);
         expv[4] = inwin(mt, mh + md, mh);
         expv[3] = inwin(mt, mh + md, ms);
         expv[2] = inwin(mt, mh + md + ms + md, ms);
         expv[1] = inwin(mt, 0, ms);
         expv[0] = inwin(mt, ms + md, ms);
         if (mt == 2*(mh + md) - 1) begin mt = 0; latch_cfg(); end
         else mt++;
      end
      @(negedge clk);
      if (tag == "R1")
         chk("R1", {main_a | main_b | shift_a, shift_b | mirr_a | mirr_b}, 2'b00);
      chk("R3", {main_a, main_b}, expv[5:4]);
      chk("R4", {shift_a, shift_b}, expv[3:2]);
      chk("R5", {mirr_a, mirr_b}, expv[1:0]);
      chk("R2", {1'b0, main_a & main_b}, 2'b00);
      chk("R6", {shift_a & shift_b, mirr_a & mirr_b}, 2'b00);
      if (tag == "R7" || tag == "R8")
         chk(tag, {main_a, main_b, shift_a, shift_b, mirr_a, mirr_b} == expv ? 2'b01 : 2'b10, 2'b01);
      // R2 dead gap: a fall of one main phase never meets the other high
      if (!rst && ((prev[5] && !main_a) || (prev[4] && !main_b)))
         chk("R2", {main_a, main_b}, 2'b00);
      prev = {main_a, main_b, shift_a, shift_b, mirr_a, mirr_b};
   endtask

   task automatic run_periods(string tag, int n);
      int per;
      per = 2 * (fix_h(int'(half_cyc), fix_s(int'(sub_cyc)), fix_d(int'(dead_cyc)))
                 + fix_d(int'(dead_cyc)));
      for (int i = 0; i < n * per + 2; i++) tick(tag);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      prev = '0;
      seed = $urandom(32'd4711);
      dead_cyc = 8'd2; sub_cyc = 8'd3; half_cyc = 8'd10;
      for (int i = 0; i < 3; i++) tick("R1");
      rst = 1'b0;
      run_periods("R3", 3);
      // R7: all zero settings -> D=1, S=1, H=3
      rst = 1'b1; dead_cyc = '0; sub_cyc = '0; half_cyc = '0;
      tick("R1"); tick("R1"); rst = 1'b0;
      run_periods("R7", 3);
      // R7: undersized main length
      rst = 1'b1; dead_cyc = 8'd4; sub_cyc = 8'd6; half_cyc = 8'd5;
      tick("R1"); rst = 1'b0;
      run_periods("R7", 2);
      // near-maximum settings
      rst = 1'b1; dead_cyc = 8'd255; sub_cyc = 8'd200; half_cyc = 8'd255;
      tick("R1"); rst = 1'b0;
      run_periods("R3", 2);
      // random legal and illegal settings, applied at reset
      for (int k = 0; k < 30; k++) begin
         rst = 1'b1;
         dead_cyc = W'($urandom_range(0, 6));
         sub_cyc  = W'($urandom_range(0, 12));
         half_cyc = W'($urandom_range(0, 60));
         tick("R1"); rst = 1'b0;
         run_periods("R4", 2);
      end
      // R8: settings redrawn every cycle, only boundary values count
      for (int i = 0; i < 3000; i++) begin
         dead_cyc = W'($urandom_range(0, 5));
         sub_cyc  = W'($urandom_range(0, 9));
         half_cyc = W'($urandom_range(0, 40));
         tick("R8");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule